// File: doc/BRIEF.md
# Quad-Port Transmit Cell Buffer with Cell-Available Flags

This block sits on the transmit side of a four-port cell-based physical-layer device. An upstream device writes whole fixed-length cells over one shared bus, clocked by a single write clock. A port number latched during idle cycles steers each cell to one of four private FIFOs. Every FIFO holds four complete cells. Each port drives a cell-available flag that tells the upstream device whether one more complete cell may be sent. The flag drops partway through the payload of the cell that reaches a programmed full level of one to four cells, so the writer learns early that it must stop.

The bus is either 8 bits wide, with 53 transfers per cell (5 header, then 48 payload), or 16 bits wide, with 27 transfers per cell (3 header, then 24 payload). On the write side `wr_valid` qualifies each transfer and there is no per-transfer back-pressure. Flow control is per cell and comes only through the flag. A cell that finds its FIFO physically full is thrown away and a sticky overflow bit is raised. The read side is a valid/ready stream that drains the head cell of the port chosen by `rd_port`. A word moves only in a cycle where `rd_valid` and `rd_ready` are both high. `rd_valid` may be held low by the block at any time, and data is held stable while the consumer stalls. Storage, and with it the flag, is released only when the last word of a cell is accepted. The configuration inputs may change only while both sides are idle.

Top module: `txq_top`

## Requirements
- R1: After reset, all four `cell_avail` outputs are high (with `cfg_inv`=0), `overflow` is 0, `cell_rdy` is 0 and `rd_valid` is 0.
- R2: A cell is 53 transfers when `cfg_bus16`=0 and 27 transfers when `cfg_bus16`=1. The first transfer carries `wr_soc`=1. A port's `cell_rdy` rises only after the last transfer of a cell. Reads return that cell's transfers in write order, with `rd_last`=1 on the final one. In 8-bit mode `rd_data[15:8]` reads as zero.
- R3: The payload position at which the flag drops depends on the mode. In 8-bit mode it is payload byte 43 (transfer index 47 from 0) when `cfg_early`=1, or byte 47 (index 51) when `cfg_early`=0. In 16-bit mode it is payload word 19 (index 21) when `cfg_early`=1, or word 23 (index 25) when `cfg_early`=0. The flag drops on the edge that samples that transfer of the cell that brings the fill to the full level.
- R4: The full level is `cfg_thr`+1 cells (1 to 4). While fewer cells than that are stored, or are past their drop position, the flag stays asserted.
- R5: With `cfg_inv`=1, every `cell_avail` bit is the inverse of its normal value.
- R6: A start of cell to a port that already stores four complete cells drops the whole cell and sets that port's `overflow` bit. The bit stays set until reset.
- R7: `wr_port` is sampled only on edges where `wr_valid`=0. Changing `wr_port` during transfers does not redirect them.
- R8: Transfers without `wr_soc` to a port that has no open cell are ignored.
- R9: A read word advances only when `rd_valid` and `rd_ready` are both high, and `rd_data` is held while `rd_ready` is low. After the last word of a cell is accepted, `cell_avail` reasserts on the next cycle if the remaining fill is below the full level.
- R10: When one port commits a written cell and pops a read cell in the same cycle, its fill is unchanged and the flag reflects that fill.
- R11: Ports are independent: traffic on one port changes no other port's flag or data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write and read clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_bus16 | input | 1 | 1: 16-bit bus, 27-transfer cells; 0: 8-bit bus, 53-transfer cells |
| cfg_early | input | 1 | 1: early flag drop position; 0: late position |
| cfg_thr | input | 2 | Full level minus one, in cells |
| cfg_inv | input | 1 | Invert all cell-available flags |
| wr_port | input | 2 | Write target, latched while `wr_valid` is low |
| wr_valid | input | 1 | Write transfer strobe |
| wr_soc | input | 1 | Marks the first transfer of a cell |
| wr_data | input | 16 | Write data (low byte only in 8-bit mode) |
| cell_avail | output | 4 | Per-port cell-available flag |
| overflow | output | 4 | Per-port sticky dropped-cell indication |
| rd_port | input | 2 | Port whose head cell is read |
| rd_ready | input | 1 | Consumer accepts the current word |
| rd_valid | output | 1 | Selected port has a complete cell to read |
| rd_data | output | 16 | Current word of the head cell |
| rd_last | output | 1 | Current word is the final one of the cell |
| cell_rdy | output | 4 | Per-port: at least one complete cell stored |

## Verification
The write path can commit the last transfer of a cell in the same cycle that the read path accepts the last word of the head cell on the same port. The fill counter then sees both an increment and a decrement. This is provoked by holding one complete cell on a port with a full level of two, then writing a second cell and reading the first one in lock-step, so that both end on one edge. The flag is judged low from the drop position up to that edge and high right after it. `cell_rdy` must stay high, and a following read must return the second cell intact.

// File: rtl/txq_pkg.sv
package txq_pkg;
  localparam int TXQ_PORTS = 4;
  localparam int TXQ_SLOTS = 4;
  localparam int TXQ_DW    = 16;
  localparam int LEN8      = 53;
  localparam int LEN16     = 27;
  localparam int HDR8      = 5;
  localparam int HDR16     = 3;
  localparam int IDXW      = $clog2(LEN8);

  // transfers per cell in the current mode
  function automatic logic [IDXW-1:0] cell_len(input logic bus16);
    return bus16 ? IDXW'(LEN16) : IDXW'(LEN8);
  endfunction

  // 0-based transfer index of the payload unit that drops the flag
  function automatic logic [IDXW-1:0] drop_idx(input logic bus16, input logic early);
    int pay;
    if (bus16) pay = early ? 19 : 23;
    else       pay = early ? 43 : 47;
    return IDXW'((bus16 ? HDR16 : HDR8) + pay - 1);
  endfunction
endpackage

// File: rtl/txq_wsel.sv
module txq_wsel #(
  parameter int NPORTS = txq_pkg::TXQ_PORTS,
  localparam int PW = $clog2(NPORTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PW-1:0]     wr_port,
  input  logic              wr_valid,
  output logic [NPORTS-1:0] wr_hit
);
  logic [PW-1:0] port_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         port_q <= '0;
    else if (!wr_valid) port_q <= wr_port;
  end

  for (genvar i = 0; i < NPORTS; i++) begin : g_hit
    assign wr_hit[i] = wr_valid && (port_q == PW'(i));
  end

  // R7: target only changes across idle cycles
  p_port_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && $past(wr_valid)) |-> $stable(port_q));
  p_one_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_hit));
endmodule

// File: rtl/txq_port.sv
module txq_port
  import txq_pkg::*;
#(
  parameter int SLOTS = TXQ_SLOTS,
  parameter int DW    = TXQ_DW,
  localparam int SW    = $clog2(SLOTS),
  localparam int CW    = $clog2(SLOTS + 1),
  localparam int DEPTH = SLOTS * LEN8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_bus16,
  input  logic          cfg_early,
  input  logic [SW-1:0] cfg_thr,
  input  logic          cfg_inv,
  input  logic          wr_en,
  input  logic          wr_soc,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_sel,
  input  logic          rd_ready,
  output logic          cell_rdy,
  output logic [DW-1:0] head_data,
  output logic          head_last,
  output logic          avail,
  output logic          ovf
);
  logic [DW-1:0]   mem [DEPTH];
  logic [CW-1:0]   cnt, cnt_n;
  logic            act, act_n, mk, mk_n, ovf_q, ovf_n, avail_q;
  logic [IDXW-1:0] widx, widx_n, ridx, len, mark;
  logic [SW-1:0]   wslot, wslot_n, rslot;
  logic            we, commit, pop;
  logic [DW-1:0]   wdata_st;
  logic [CW:0]     lvl, full_lvl;

  assign len  = cell_len(cfg_bus16);
  assign mark = drop_idx(cfg_bus16, cfg_early);
  assign wdata_st = cfg_bus16 ? wr_data : {{(DW/2){1'b0}}, wr_data[DW/2-1:0]};

  function automatic logic [AW-1:0] addr(input logic [SW-1:0] s, input logic [IDXW-1:0] i);
    return AW'(AW'(s) * AW'(LEN8) + AW'(i));
  endfunction

  function automatic logic [SW-1:0] nxt(input logic [SW-1:0] s);
    return (s == SW'(SLOTS - 1)) ? '0 : s + 1'b1;
  endfunction

  // write-side next state
  always_comb begin
    act_n   = act;
    mk_n    = mk;
    widx_n  = widx;
    wslot_n = wslot;
    ovf_n   = ovf_q;
    we      = 1'b0;
    commit  = 1'b0;
    if (wr_en && wr_soc) begin
      mk_n = 1'b0;
      if (cnt == CW'(SLOTS)) begin
        ovf_n = 1'b1;
        act_n = 1'b0;
      end else begin
        we     = 1'b1;
        act_n  = 1'b1;
        widx_n = IDXW'(1);
      end
    end else if (wr_en && act) begin
      we = 1'b1;
      if (widx == mark) mk_n = 1'b1;
      if (widx == len - 1'b1) begin
        act_n   = 1'b0;
        mk_n    = 1'b0;
        widx_n  = '0;
        wslot_n = nxt(wslot);
        commit  = 1'b1;
      end else begin
        widx_n = widx + 1'b1;
      end
    end
  end

  assign cell_rdy  = (cnt != '0);
  assign head_data = mem[addr(rslot, ridx)];
  assign head_last = (ridx == len - 1'b1);
  assign pop       = rd_sel && rd_ready && cell_rdy && head_last;

  assign cnt_n    = cnt + CW'(commit) - CW'(pop);
  assign lvl      = {1'b0, cnt_n} + (CW+1)'(mk_n);
  assign full_lvl = (CW+1)'(cfg_thr) + 1'b1;

  always_ff @(posedge clk) begin
    if (we) mem[addr(wslot, wr_soc ? '0 : widx)] <= wdata_st;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0; act <= 1'b0; mk <= 1'b0; ovf_q <= 1'b0; avail_q <= 1'b1;
      widx <= '0; wslot <= '0; ridx <= '0; rslot <= '0;
    end else begin
      cnt     <= cnt_n;
      act     <= act_n;
      mk      <= mk_n;
      ovf_q   <= ovf_n;
      widx    <= widx_n;
      wslot   <= wslot_n;
      avail_q <= (lvl < full_lvl);
      if (rd_sel && rd_ready && cell_rdy) begin
        if (head_last) begin
          ridx  <= '0;
          rslot <= nxt(rslot);
        end else begin
          ridx <= ridx + 1'b1;
        end
      end
    end
  end

  assign avail = avail_q ^ cfg_inv;
  assign ovf   = ovf_q;

  p_cnt_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(SLOTS));
  p_full_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CW'(SLOTS)) |-> !avail_q);
  p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);
  p_drop_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_soc && cnt == CW'(SLOTS)) |=> ovf_q);
  p_mark_in_cell_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mk |-> act);
  p_read_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ridx != $past(ridx)) |-> $past(rd_sel && rd_ready && cell_rdy));
endmodule

// File: rtl/txq_rmux.sv
module txq_rmux #(
  parameter int NPORTS = txq_pkg::TXQ_PORTS,
  parameter int DW     = txq_pkg::TXQ_DW,
  localparam int PW = $clog2(NPORTS)
) (
  input  logic [PW-1:0]              rd_port,
  input  logic [NPORTS-1:0]          rdy,
  input  logic [NPORTS-1:0][DW-1:0]  data,
  input  logic [NPORTS-1:0]          last,
  output logic [NPORTS-1:0]          sel,
  output logic                       rd_valid,
  output logic [DW-1:0]              rd_data,
  output logic                       rd_last
);
  for (genvar i = 0; i < NPORTS; i++) begin : g_sel
    assign sel[i] = (rd_port == PW'(i));
  end
  assign rd_valid = rdy[rd_port];
  assign rd_data  = data[rd_port];
  assign rd_last  = last[rd_port];
endmodule

// File: rtl/txq_top.sv
module txq_top
  import txq_pkg::*;
#(
  parameter int NPORTS = TXQ_PORTS,
  parameter int SLOTS  = TXQ_SLOTS,
  parameter int DW     = TXQ_DW,
  localparam int PW = $clog2(NPORTS),
  localparam int TW = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_bus16,
  input  logic              cfg_early,
  input  logic [TW-1:0]     cfg_thr,
  input  logic              cfg_inv,
  input  logic [PW-1:0]     wr_port,
  input  logic              wr_valid,
  input  logic              wr_soc,
  input  logic [DW-1:0]     wr_data,
  output logic [NPORTS-1:0] cell_avail,
  output logic [NPORTS-1:0] overflow,
  input  logic [PW-1:0]     rd_port,
  input  logic              rd_ready,
  output logic              rd_valid,
  output logic [DW-1:0]     rd_data,
  output logic              rd_last,
  output logic [NPORTS-1:0] cell_rdy
);
  logic [NPORTS-1:0]         wr_hit, sel, last;
  logic [NPORTS-1:0][DW-1:0] data;

  txq_wsel #(.NPORTS(NPORTS)) i_wsel (
    .clk(clk), .rst_n(rst_n), .wr_port(wr_port), .wr_valid(wr_valid), .wr_hit(wr_hit));

  for (genvar i = 0; i < NPORTS; i++) begin : g_port
    txq_port #(.SLOTS(SLOTS), .DW(DW)) i_port (
      .clk(clk), .rst_n(rst_n),
      .cfg_bus16(cfg_bus16), .cfg_early(cfg_early), .cfg_thr(cfg_thr), .cfg_inv(cfg_inv),
      .wr_en(wr_hit[i]), .wr_soc(wr_soc), .wr_data(wr_data),
      .rd_sel(sel[i]), .rd_ready(rd_ready),
      .cell_rdy(cell_rdy[i]), .head_data(data[i]), .head_last(last[i]),
      .avail(cell_avail[i]), .ovf(overflow[i]));
  end

  txq_rmux #(.NPORTS(NPORTS), .DW(DW)) i_rmux (
    .rd_port(rd_port), .rdy(cell_rdy), .data(data), .last(last),
    .sel(sel), .rd_valid(rd_valid), .rd_data(rd_data), .rd_last(rd_last));
endmodule

// File: tb/test_txq_top.sv
module test_txq_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n, cfg_bus16, cfg_early, cfg_inv, wr_valid, wr_soc, rd_ready;
  logic [1:0]  cfg_thr, wr_port, rd_port;
  logic [15:0] wr_data, rd_data;
  logic [3:0]  cell_avail, overflow, cell_rdy;
  logic        rd_valid, rd_last;
  int          n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  txq_top i_txq_top (
    .clk(clk), .rst_n(rst_n), .cfg_bus16(cfg_bus16), .cfg_early(cfg_early),
    .cfg_thr(cfg_thr), .cfg_inv(cfg_inv), .wr_port(wr_port), .wr_valid(wr_valid),
    .wr_soc(wr_soc), .wr_data(wr_data), .cell_avail(cell_avail), .overflow(overflow),
    .rd_port(rd_port), .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_last(rd_last), .cell_rdy(cell_rdy));

  // {mark[15:8], bus16[7], early[6], thr[5:4], inv[3], port[1:0]}
  localparam logic [15:0] VEC [6] = '{
    {8'd47, 8'h40}, {8'd51, 8'h31}, {8'd21, 8'hDA},
    {8'd25, 8'hA3}, {8'd51, 8'h18}, {8'd21, 8'hF1}};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] pat(input int p, input int c, input int i, input logic b16);
    logic [7:0] lo, hi;
    lo = 8'(i) ^ {4'(c), 2'b00, 2'(p)};
    hi = {4'(p) + 4'h1, 4'(c)};
    return b16 ? {hi, lo} : {8'h00, lo};
  endfunction

  task automatic do_reset();
    rst_n = 0; wr_valid = 0; wr_soc = 0; wr_data = '0; wr_port = '0;
    rd_port = '0; rd_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic push(input int p, input logic [15:0] d, input logic soc);
    @(negedge clk);
    wr_port = 2'(p) ^ 2'b01;   // R7: wrong target while transferring
    wr_valid = 1; wr_soc = soc; wr_data = d;
    @(negedge clk);
    wr_valid = 0; wr_soc = 0; wr_port = 2'(p);
  endtask

  task automatic write_cell(input int p, input int c, input logic chk_flag,
                            input int t, input int mark);
    int len;
    logic exp;
    len = cfg_bus16 ? 27 : 53;
    wr_port = 2'(p);
    @(negedge clk);
    for (int i = 0; i < len; i++) begin
      push(p, pat(p, c, i, 1'b1), i == 0);
      if (chk_flag) begin
        exp = !(c == t - 1 && i >= mark);
        if (c == t - 1) chk("R3 flag drop position", cell_avail[p], exp ^ cfg_inv);
        else            chk("R4 flag below full level", cell_avail[p], exp ^ cfg_inv);
      end
    end
  endtask

  task automatic read_cell(input int p, input int c, input logic stall);
    int len;
    len = cfg_bus16 ? 27 : 53;
    @(negedge clk);
    rd_port = 2'(p); rd_ready = 0;
    for (int i = 0; i < len; i++) begin
      #1;
      chk("R2 rd_valid", rd_valid, 1);
      chk("R2 rd_data order", rd_data, pat(p, c, i, cfg_bus16));
      chk("R2 rd_last", rd_last, i == len - 1);
      if (stall && i == 1) begin
        rd_ready = 0;
        @(negedge clk); #1;
        chk("R9 data held in stall", rd_data, pat(p, c, i, cfg_bus16));
      end
      rd_ready = 1;
      @(negedge clk);
      rd_ready = 0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    cfg_bus16 = 0; cfg_early = 0; cfg_thr = 2'd3; cfg_inv = 0;
    do_reset();

    // R1 reset state
    #1;
    chk("R1 cell_avail", cell_avail, 4'hF);
    chk("R1 overflow", overflow, 4'h0);
    chk("R1 cell_rdy", cell_rdy, 4'h0);
    chk("R1 rd_valid", rd_valid, 0);
    cfg_inv = 1; #1;
    chk("R5 inverted flags", cell_avail, 4'h0);
    cfg_inv = 0;

    // table walk: R3 R4 R5 R11 R9
    for (int v = 0; v < 6; v++) begin
      int p, t, mark;
      logic [15:0] e;
      e = VEC[v];
      do_reset();
      cfg_bus16 = e[7]; cfg_early = e[6]; cfg_thr = e[5:4]; cfg_inv = e[3];
      p = int'(e[1:0]); t = int'(e[5:4]) + 1; mark = int'(e[15:8]);
      for (int c = 0; c < t; c++) write_cell(p, c, 1'b1, t, mark);
      for (int q = 0; q < 4; q++)
        if (q != p) chk("R11 other port flag", cell_avail[q], 1'b1 ^ cfg_inv);
      chk("R2 cell_rdy after commit", cell_rdy[p], 1);
      read_cell(p, 0, e[0]);
      chk("R9 flag back after pop", cell_avail[p], 1'b1 ^ cfg_inv);
    end

    // R8 stray transfers with no open cell
    do_reset();
    cfg_bus16 = 0; cfg_early = 0; cfg_thr = 2'd3; cfg_inv = 0;
    for (int i = 0; i < 5; i++) push(1, 16'h00EE, 1'b0);
    chk("R8 stray words no cell", cell_rdy, 4'h0);
    chk("R8 stray words no flag change", cell_avail, 4'hF);
    write_cell(1, 2, 1'b0, 4, 51);
    read_cell(1, 2, 1'b0);
    chk("R8 no residue", cell_rdy, 4'h0);

    // R6 overflow drops a whole cell
    do_reset();
    for (int c = 0; c < 4; c++) write_cell(2, c, 1'b1, 4, 51);
    chk("R6 no overflow at capacity", overflow, 4'h0);
    write_cell(2, 4, 1'b0, 4, 51);
    chk("R6 overflow set", overflow, 4'b0100);
    chk("R4 flag low when full", cell_avail[2], 0);
    for (int c = 0; c < 4; c++) read_cell(2, c, 1'b0);
    #1;
    chk("R6 fifth cell dropped", cell_rdy[2], 0);
    chk("R6 rd_valid empty", rd_valid, 0);
    chk("R6 overflow sticky", overflow, 4'b0100);

    // R10 commit and pop on one edge
    do_reset();
    cfg_thr = 2'd1;
    write_cell(3, 0, 1'b1, 2, 51);
    @(negedge clk);
    rd_port = 2'd3; wr_port = 2'd3;
    @(negedge clk);
    for (int i = 0; i < 53; i++) begin
      wr_valid = 1; wr_soc = (i == 0); wr_data = pat(3, 1, i, 1'b1); rd_ready = 1;
      #1;
      chk("R10 read during write", rd_data, pat(3, 0, i, 1'b0));
      @(negedge clk);
      chk("R10 flag during overlap", cell_avail[3], !(i >= 51 && i < 52));
    end
    wr_valid = 0; wr_soc = 0; rd_ready = 0;
    chk("R10 fill kept", cell_rdy[3], 1);
    chk("R10 flag high", cell_avail[3], 1);
    read_cell(3, 1, 1'b0);
    #1;
    chk("R10 drained", cell_rdy, 4'h0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule